// File: doc/BRIEF.md
# H-Bridge Command Decoder with Fault Latch

This block sits between a motor controller's command pins and the gate drive of a two-leg H-bridge. It turns the enable, the two direction inputs, an input-invert control and a pair of disable inputs of opposite sense into a drive state for each leg: driven high, driven low or released to high impedance. It also produces an active-low status flag for the controller.

Three fault inputs feed it: supply undervoltage, overtemperature (with a separate "cooled below the release threshold" indication) and short circuit. Undervoltage releases the bridge only while it is present. Short circuit and overtemperature latch the bridge off until the controller sends a clear event: a falling edge on the active-high disable, a rising edge on the active-low disable, or any change of enable. A power-on reset also clears the latches. Every input passes through a synchronizer, and the edge detection uses the synchronized values. The drive states and the flag are registered.

Top module: `hbridge_ctrl`

## Requirements
- R1: With enable 1, no disable asserted, no fault and invert 0, each leg follows its direction input. Input 1 gives state 2'b01 (high) and input 0 gives state 2'b00 (low), so all four combinations are reachable: forward, reverse, freewheel low and freewheel high. The status flag is 1 and the code 2'b11 never appears.
- R2: With invert 1, both direction inputs are active-low. A leg whose input is 0 drives high (2'b01) and a leg whose input is 1 drives low (2'b00).
- R3: With enable 1, active-high disable at 1 or active-low disable at 0 puts both legs in state 2'b10 (high impedance) and drives the status flag to 0.
- R4: With enable 0 (sleep), both legs are 2'b10 and the status flag is 1. This holds whatever the other inputs and the latched faults are.
- R5: While undervoltage is 1 and enable is 1, both legs are 2'b10 and the flag is 0. When undervoltage returns to 0, the commanded states and flag 1 come back with no other action.
- R6: A short circuit or overtemperature pulse latches both legs to 2'b10 and the flag to 0. The latch stays set after the fault input returns to 0, and changes on the direction and invert inputs do not affect it.
- R7: A 1-to-0 edge of the active-high disable clears a latched fault.
- R8: A 0-to-1 edge of the active-low disable clears a latched fault.
- R9: A change of enable in either direction clears a latched fault.
- R10: A latched overtemperature clears only if the cooled indication is 1 at the clear event. A clear event while cooled is 0 leaves it latched.
- R11: If a fault input is still 1 at a clear event, the latch stays set, because setting wins over clearing. No later clear happens without a new edge.
- R12: Power-on reset clears both fault latches and puts out state 2'b10 on both legs with flag 1.
- R13: After an input change, the outputs take their new value within SYNC_STAGES+2 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| en_i | input | 1 | Enable; 0 selects sleep |
| dir_a_i | input | 1 | Direction input for leg A |
| dir_b_i | input | 1 | Direction input for leg B |
| inv_i | input | 1 | Treat direction inputs as active-low |
| dis_hi_i | input | 1 | Disable, active high |
| dis_lo_n_i | input | 1 | Disable, active low |
| uv_i | input | 1 | Supply undervoltage present |
| ot_i | input | 1 | Overtemperature present |
| ot_cool_i | input | 1 | Temperature below the release threshold |
| sc_i | input | 1 | Short circuit present |
| leg_a_o | output | 2 | Leg A state: 01 high, 00 low, 10 high impedance |
| leg_b_o | output | 2 | Leg B state: 01 high, 00 low, 10 high impedance |
| flag_n_o | output | 1 | Status flag, active low |

## Verification
The assertions assume the overtemperature and cooled indications are never both 1. A fault only has to be seen after synchronization to latch, so any pulse held for at least one cycle at the synchronizer output is enough. The directed stimulus keeps the cooled indication at 0 whenever overtemperature is 1. It holds every input level for several cycles, longer than the synchronizer depth, so each edge reaches the edge detector as a single clean transition. Every check is sampled only after the input has had SYNC_STAGES+2 cycles to propagate.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        LEG_LOW  = 2'b00,
        LEG_HIGH = 2'b01,
        LEG_OFF  = 2'b10
    } leg_t;

    typedef struct packed {
        leg_t leg_a;
        leg_t leg_b;
        logic flag_n;
    } drive_t;

    // Index of each pin within the synchronized bundle
    localparam int PIN_EN    = 0;
    localparam int PIN_DIRA  = 1;
    localparam int PIN_DIRB  = 2;
    localparam int PIN_INV   = 3;
    localparam int PIN_DISH  = 4;
    localparam int PIN_DISLN = 5;
    localparam int PIN_UV    = 6;
    localparam int PIN_OT    = 7;
    localparam int PIN_COOL  = 8;
    localparam int PIN_SC    = 9;
    localparam int PIN_COUNT = 10;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign stage_d[s] = async_i;
            end else begin : g_rest
                assign stage_d[s] = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch #(
    parameter logic EN_RST    = 1'b0,
    parameter logic DISH_RST  = 1'b1,
    parameter logic DISLN_RST = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_s,
    input  logic dis_hi_s,
    input  logic dis_lo_n_s,
    input  logic sc_s,
    input  logic ot_s,
    input  logic ot_cool_s,
    output logic sc_lat_o,
    output logic ot_lat_o
);

    typedef struct packed {
        logic en_prev;
        logic dish_prev;
        logic disln_prev;
        logic sc_lat;
        logic ot_lat;
    } lat_t;

    lat_t st_d, st_q;
    logic clr_evt;

    always_comb begin
        clr_evt = (st_q.dish_prev & ~dis_hi_s)
                | (~st_q.disln_prev & dis_lo_n_s)
                | (st_q.en_prev ^ en_s);

        st_d            = st_q;
        st_d.en_prev    = en_s;
        st_d.dish_prev  = dis_hi_s;
        st_d.disln_prev = dis_lo_n_s;

        // Setting has priority over clearing (R11)
        if (sc_s)         st_d.sc_lat = 1'b1;
        else if (clr_evt) st_d.sc_lat = 1'b0;

        // Overtemperature needs the cooled indication to release (R10)
        if (ot_s)                        st_d.ot_lat = 1'b1;
        else if (clr_evt && ot_cool_s)   st_d.ot_lat = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en_prev    <= EN_RST;
            st_q.dish_prev  <= DISH_RST;
            st_q.disln_prev <= DISLN_RST;
            st_q.sc_lat     <= 1'b0;
            st_q.ot_lat     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sc_lat_o = st_q.sc_lat;
    assign ot_lat_o = st_q.ot_lat;

endmodule

// File: rtl/hb_decode.sv
module hb_decode
    import hb_pkg::*;
(
    input  logic   en,
    input  logic   dir_a,
    input  logic   dir_b,
    input  logic   inv,
    input  logic   dis_hi,
    input  logic   dis_lo_n,
    input  logic   uv,
    input  logic   fault_lat,
    output drive_t drive
);

    logic off_req;
    logic eff_a, eff_b;

    always_comb begin
        off_req = dis_hi | ~dis_lo_n | uv | fault_lat;
        eff_a   = dir_a ^ inv;
        eff_b   = dir_b ^ inv;

        if (!en) begin
            drive.leg_a  = LEG_OFF;
            drive.leg_b  = LEG_OFF;
            drive.flag_n = 1'b1;
        end else if (off_req) begin
            drive.leg_a  = LEG_OFF;
            drive.leg_b  = LEG_OFF;
            drive.flag_n = 1'b0;
        end else begin
            drive.leg_a  = eff_a ? LEG_HIGH : LEG_LOW;
            drive.leg_b  = eff_b ? LEG_HIGH : LEG_LOW;
            drive.flag_n = 1'b1;
        end
    end

endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
    import hb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       dir_a_i,
    input  logic       dir_b_i,
    input  logic       inv_i,
    input  logic       dis_hi_i,
    input  logic       dis_lo_n_i,
    input  logic       uv_i,
    input  logic       ot_i,
    input  logic       ot_cool_i,
    input  logic       sc_i,
    output logic [1:0] leg_a_o,
    output logic [1:0] leg_b_o,
    output logic       flag_n_o
);

    // Reset values match the pins' idle (safe) levels
    localparam logic [PIN_COUNT-1:0] PIN_RST =
        (PIN_COUNT'(1) << PIN_DIRA) | (PIN_COUNT'(1) << PIN_DIRB) |
        (PIN_COUNT'(1) << PIN_DISH) | (PIN_COUNT'(1) << PIN_COOL);

    logic [PIN_COUNT-1:0] pins_raw, pins_s;
    logic en_s, dir_a_s, dir_b_s, inv_s, dis_hi_s, dis_lo_n_s;
    logic uv_s, ot_s, ot_cool_s, sc_s;
    logic sc_lat, ot_lat;
    drive_t drv_d, drv_q;

    always_comb begin
        pins_raw            = '0;
        pins_raw[PIN_EN]    = en_i;
        pins_raw[PIN_DIRA]  = dir_a_i;
        pins_raw[PIN_DIRB]  = dir_b_i;
        pins_raw[PIN_INV]   = inv_i;
        pins_raw[PIN_DISH]  = dis_hi_i;
        pins_raw[PIN_DISLN] = dis_lo_n_i;
        pins_raw[PIN_UV]    = uv_i;
        pins_raw[PIN_OT]    = ot_i;
        pins_raw[PIN_COOL]  = ot_cool_i;
        pins_raw[PIN_SC]    = sc_i;
    end

    hb_sync #(
        .WIDTH  (PIN_COUNT),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_RST)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pins_raw),
        .sync_o (pins_s)
    );

    assign en_s       = pins_s[PIN_EN];
    assign dir_a_s    = pins_s[PIN_DIRA];
    assign dir_b_s    = pins_s[PIN_DIRB];
    assign inv_s      = pins_s[PIN_INV];
    assign dis_hi_s   = pins_s[PIN_DISH];
    assign dis_lo_n_s = pins_s[PIN_DISLN];
    assign uv_s       = pins_s[PIN_UV];
    assign ot_s       = pins_s[PIN_OT];
    assign ot_cool_s  = pins_s[PIN_COOL];
    assign sc_s       = pins_s[PIN_SC];

    hb_fault_latch #(
        .EN_RST   (PIN_RST[PIN_EN]),
        .DISH_RST (PIN_RST[PIN_DISH]),
        .DISLN_RST(PIN_RST[PIN_DISLN])
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_s      (en_s),
        .dis_hi_s  (dis_hi_s),
        .dis_lo_n_s(dis_lo_n_s),
        .sc_s      (sc_s),
        .ot_s      (ot_s),
        .ot_cool_s (ot_cool_s),
        .sc_lat_o  (sc_lat),
        .ot_lat_o  (ot_lat)
    );

    hb_decode u_decode (
        .en       (en_s),
        .dir_a    (dir_a_s),
        .dir_b    (dir_b_s),
        .inv      (inv_s),
        .dis_hi   (dis_hi_s),
        .dis_lo_n (dis_lo_n_s),
        .uv       (uv_s),
        .fault_lat(sc_lat | ot_lat),
        .drive    (drv_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q.leg_a  <= LEG_OFF;
            drv_q.leg_b  <= LEG_OFF;
            drv_q.flag_n <= 1'b1;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign leg_a_o  = drv_q.leg_a;
    assign leg_b_o  = drv_q.leg_b;
    assign flag_n_o = drv_q.flag_n;

endmodule

// File: rtl/hbridge_ctrl_chk.sv
module hbridge_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_s,
    input logic       sc_s,
    input logic       ot_cool_s,
    input logic       sc_lat,
    input logic       ot_lat,
    input logic [1:0] leg_a,
    input logic [1:0] leg_b,
    input logic       flag_n
);

    assert_no_bad_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (leg_a != 2'b11) && (leg_b != 2'b11));

    assert_flag_low_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_n |-> (leg_a == 2'b10) && (leg_b == 2'b10));

    assert_sleep_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> (leg_a == 2'b10) && (leg_b == 2'b10) && flag_n);

    assert_sc_sets_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sc_s |=> sc_lat);

    assert_hot_holds_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_lat && !ot_cool_s) |=> ot_lat);

    assert_sc_wins_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_lat && sc_s) |=> sc_lat);

endmodule

bind hbridge_ctrl hbridge_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_s     (en_s),
    .sc_s     (sc_s),
    .ot_cool_s(ot_cool_s),
    .sc_lat   (sc_lat),
    .ot_lat   (ot_lat),
    .leg_a    (leg_a_o),
    .leg_b    (leg_b_o),
    .flag_n   (flag_n_o)
);

// File: tb/hbridge_ctrl_tb.sv
module hbridge_ctrl_tb;

    localparam int SYNC = 2;
    localparam int SETTLE = SYNC + 2;
    localparam logic [1:0] LO = 2'b00;
    localparam logic [1:0] HI = 2'b01;
    localparam logic [1:0] OFF = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, dir_a = 1'b1, dir_b = 1'b1, inv = 1'b0;
    logic dis_hi = 1'b1, dis_lo_n = 1'b0;
    logic uv = 1'b0, ot = 1'b0, ot_cool = 1'b1, sc = 1'b0;
    logic [1:0] leg_a, leg_b;
    logic flag_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hbridge_ctrl #(.SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .dir_a_i(dir_a), .dir_b_i(dir_b),
        .inv_i(inv), .dis_hi_i(dis_hi), .dis_lo_n_i(dis_lo_n), .uv_i(uv),
        .ot_i(ot), .ot_cool_i(ot_cool), .sc_i(sc),
        .leg_a_o(leg_a), .leg_b_o(leg_b), .flag_n_o(flag_n)
    );

    task automatic settle();
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(string tag, logic [1:0] ea, logic [1:0] eb, logic ef);
        checks++;
        if (leg_a !== ea || leg_b !== eb || flag_n !== ef) begin
            fails++;
            $display("FAIL %s: got a=%b b=%b flag_n=%b, expected a=%b b=%b flag_n=%b",
                     tag, leg_a, leg_b, flag_n, ea, eb, ef);
        end
    endtask

    task automatic go_active();
        en = 1'b1; dis_hi = 1'b0; dis_lo_n = 1'b1; inv = 1'b0;
        settle();
    endtask

    // A high pulse on the active-high disable; its falling edge is a clear
    task automatic pulse_dis_hi();
        dis_hi = 1'b1; settle();
        dis_hi = 1'b0; settle();
    endtask

    task automatic t_reset();
        expect_out("R12 reset state", OFF, OFF, 1'b1);
    endtask

    task automatic t_direct();
        go_active();
        dir_a = 1; dir_b = 0; settle(); expect_out("R1 forward", HI, LO, 1'b1);
        dir_a = 0; dir_b = 1; settle(); expect_out("R1 reverse", LO, HI, 1'b1);
        dir_a = 0; dir_b = 0; settle(); expect_out("R1 freewheel low", LO, LO, 1'b1);
        dir_a = 1; dir_b = 1; settle(); expect_out("R1 freewheel high", HI, HI, 1'b1);
    endtask

    task automatic t_invert();
        inv = 1;
        dir_a = 1; dir_b = 0; settle(); expect_out("R2 inverted forward", LO, HI, 1'b1);
        dir_a = 1; dir_b = 1; settle(); expect_out("R2 inverted freewheel", LO, LO, 1'b1);
        inv = 0; settle();
    endtask

    task automatic t_disable();
        dir_a = 1; dir_b = 0;
        dis_hi = 1; settle(); expect_out("R3 active-high disable", OFF, OFF, 1'b0);
        dis_hi = 0; dis_lo_n = 0; settle(); expect_out("R3 active-low disable", OFF, OFF, 1'b0);
        dis_lo_n = 1; settle(); expect_out("R3 release", HI, LO, 1'b1);
    endtask

    task automatic t_sleep();
        en = 0; dis_hi = 1; settle(); expect_out("R4 sleep with disable", OFF, OFF, 1'b1);
        dis_hi = 0; settle(); expect_out("R4 sleep", OFF, OFF, 1'b1);
        en = 1; settle(); expect_out("R4 wake", HI, LO, 1'b1);
    endtask

    task automatic t_uv();
        uv = 1; settle(); expect_out("R5 undervoltage", OFF, OFF, 1'b0);
        uv = 0; settle(); expect_out("R5 auto recovery", HI, LO, 1'b1);
    endtask

    task automatic t_sc_clear_dis_hi();
        sc = 1; @(posedge clk); @(posedge clk); sc = 0;
        settle(); expect_out("R6 short latched", OFF, OFF, 1'b0);
        dir_a = 0; dir_b = 1; inv = 1; settle();
        expect_out("R6 latch ignores direction", OFF, OFF, 1'b0);
        inv = 0; settle();
        pulse_dis_hi(); expect_out("R7 clear on disable fall", LO, HI, 1'b1);
    endtask

    task automatic t_clear_dis_lo();
        sc = 1; settle(); sc = 0; settle();
        expect_out("R6 short latched again", OFF, OFF, 1'b0);
        dis_lo_n = 0; settle(); dis_lo_n = 1; settle();
        expect_out("R8 clear on active-low disable rise", LO, HI, 1'b1);
    endtask

    task automatic t_clear_en();
        sc = 1; settle(); sc = 0; settle();
        en = 0; settle(); en = 1; settle();
        expect_out("R9 clear on enable toggle", LO, HI, 1'b1);
    endtask

    task automatic t_ot_hyst();
        ot_cool = 0; ot = 1; settle(); ot = 0; settle();
        expect_out("R6 overtemp latched", OFF, OFF, 1'b0);
        pulse_dis_hi(); expect_out("R10 no release while warm", OFF, OFF, 1'b0);
        ot_cool = 1; settle();
        expect_out("R10 cooling alone does not clear", OFF, OFF, 1'b0);
        pulse_dis_hi(); expect_out("R10 release when cool", LO, HI, 1'b1);
    endtask

    task automatic t_priority();
        sc = 1; settle();
        pulse_dis_hi(); expect_out("R11 clear ignored while short present", OFF, OFF, 1'b0);
        sc = 0; settle(); expect_out("R11 stays latched without new edge", OFF, OFF, 1'b0);
        pulse_dis_hi(); expect_out("R11 later clear works", LO, HI, 1'b1);
    endtask

    task automatic t_latency();
        dir_a = 1; dir_b = 0;
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
        expect_out("R13 latency bound", HI, LO, 1'b1);
    endtask

    task automatic t_por();
        sc = 1; settle(); sc = 0; settle();
        expect_out("R12 latched before reset", OFF, OFF, 1'b0);
        rst_n = 0; @(negedge clk);
        expect_out("R12 reset outputs", OFF, OFF, 1'b1);
        rst_n = 1; settle();
        expect_out("R12 latch cleared by reset", HI, LO, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1;
        settle();
        expect_out("R4 idle pins after reset", OFF, OFF, 1'b1);
        t_direct();
        t_invert();
        t_disable();
        t_sleep();
        t_uv();
        t_sc_clear_dis_hi();
        t_clear_dis_lo();
        t_clear_en();
        t_ot_hyst();
        t_priority();
        t_latency();
        t_por();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule